// File: doc/BRIEF.md
# Sigma-Delta Converter Mode Sequencer

This block decides when a sigma-delta converter core runs, how long it converts and where each finished result goes. Software writes a 3-bit operating mode and a 4-bit update-rate code together in one cycle. From these the sequencer times conversion periods with a tick counter and enables or halts the modulator/filter stub. It commits the stub's latest result word to the data register or to one of two calibration coefficient registers, and it drives an active-low ready flag.

The stub delivers results as a parallel word with a valid strobe. The sequencer keeps the most recent word captured while the filter runs and commits it at the end of a counted period. One update period lasts a whole number of milliseconds set by the rate code, and the tick count per millisecond is a parameter. A bench can therefore run with a few ticks per millisecond while silicon uses the real clock rate. Reset deassertion is expected to be synchronous to `clk`.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the mode is 000 (continuous), the rate is the parameter RST_RATE, ready_n is 1, cfg_err is 0, data_out, offset_coef and fullscale_coef are 0, filt_run is 1 and pwr_dn is 0.
- R2: In continuous mode (000), ready_n first falls 2·P cycles after reset release or after an accepted write, where P is the period in cycles. data_out then holds the word last captured from res_data.
- R3: In continuous mode, each later result is committed exactly P cycles after the previous one.
- R4: A read strobe sets ready_n to 1 on the next edge unless a result is committed on that edge. data_out does not change.
- R5: Single mode (001) waits CLK_KHZ cycles (1 ms) with the filter halted, then converts for 2·P cycles, commits to data_out and drives ready_n low. It then switches the mode to 011 (power-down). ready_n stays low until a read or a new accepted write.
- R6: Calibration modes 100 and 110 store the result in offset_coef, and 111 stores it in fullscale_coef, each after 2·P cycles. ready_n goes to 1 when the calibration is accepted and falls when it ends. data_out is left unchanged.
- R7: When a calibration ends, the mode becomes 010 (idle) and filt_run drops.
- R8: In idle (010) and power-down (011), filt_run is 0, nothing is committed and res_data has no effect on any output. pwr_dn is 1 only in power-down.
- R9: A write with mode 101, or with rate code 0000, 0001, 0010, 0110 or 1000, is rejected. Mode, rate, ready_n and the conversion timing are kept, and cfg_err becomes 1. The next accepted write clears cfg_err.
- R10: The period in milliseconds per rate code is 0011:8, 0100:16, 0101:20, 0111:30, 1001:60, 1010:60, 1011:80, 1100:100, 1101:120, 1110:160, 1111:240. P equals that value times CLK_KHZ.
- R11: Every accepted write restarts the sequence from its start, including in the middle of a conversion, and sets ready_n to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_KHZ ticks per millisecond |
| rst_n | input | 1 | Asynchronous active-low reset, synchronous deassertion |
| cfg_we | input | 1 | Write strobe for mode and rate |
| cfg_mode | input | 3 | Mode to write |
| cfg_rate | input | 4 | Update-rate code to write |
| rd_strobe | input | 1 | Data-read strobe, clears ready |
| res_valid | input | 1 | Result word valid from the filter stub |
| res_data | input | DW | Result word from the filter stub |
| ready_n | output | 1 | Active-low result/calibration ready flag |
| data_out | output | DW | Committed conversion result |
| offset_coef | output | DW | Offset calibration coefficient |
| fullscale_coef | output | DW | Full-scale calibration coefficient |
| cur_mode | output | 3 | Mode in force |
| cur_rate | output | 4 | Rate code in force |
| cfg_err | output | 1 | Last write was rejected |
| filt_run | output | 1 | Modulator and filter enabled |
| pwr_dn | output | 1 | Block is powered down |

## Verification
On every cycle the assertions check the following. An accepted write always raises ready_n and clears cfg_err. A rejected write leaves mode and rate alone. The reserved mode and invalid rate codes never become current. A read clears ready. Each fall of ready_n out of a calibration or a single conversion lands in idle or power-down respectively. The data register is frozen in idle and power-down. Exact latencies can only be shown by the directed scenarios: two periods before a first result, one period between results, the 1 ms oscillator wait, the per-code period lengths and a restart partway through a conversion. The same holds for which coefficient register each calibration fills.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    M_CONT   = 3'b000,
    M_SINGLE = 3'b001,
    M_IDLE   = 3'b010,
    M_PDOWN  = 3'b011,
    M_ZC_INT = 3'b100,
    M_RSVD   = 3'b101,
    M_ZC_SYS = 3'b110,
    M_FS_SYS = 3'b111
  } mode_e;

  typedef enum logic [2:0] {
    ST_CONV,
    ST_OSC,
    ST_SGL,
    ST_CAL,
    ST_IDLE,
    ST_PDN
  } seq_state_e;

  // Longest update period in milliseconds.
  localparam int unsigned MAX_MS = 240;

  // Update period in milliseconds; zero marks an unusable rate code.
  function automatic int unsigned period_ms(input logic [3:0] code);
    int unsigned ms;
    case (code)
      4'h3:    ms = 8;
      4'h4:    ms = 16;
      4'h5:    ms = 20;
      4'h7:    ms = 30;
      4'h9:    ms = 60;
      4'hA:    ms = 60;
      4'hB:    ms = 80;
      4'hC:    ms = 100;
      4'hD:    ms = 120;
      4'hE:    ms = 160;
      4'hF:    ms = 240;
      default: ms = 0;
    endcase
    return ms;
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter logic [3:0] RST_RATE = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_mode,
  input  logic [3:0] wr_rate,
  input  logic       auto_set,
  input  logic [2:0] auto_mode,
  output logic       accept,
  output logic [2:0] mode_q,
  output logic [3:0] rate_q,
  output logic       err_q
);

  logic       wr_ok;
  logic       cfg_en;
  logic [2:0] mode_d;
  logic [3:0] rate_d;
  logic       err_d;

  always_comb begin
    wr_ok  = (wr_mode != M_RSVD) && (period_ms(wr_rate) != 0);
    accept = wr_en && wr_ok;
    cfg_en = wr_en || auto_set;
    mode_d = mode_q;
    rate_d = rate_q;
    err_d  = err_q;
    if (accept) begin
      mode_d = wr_mode;
      rate_d = wr_rate;
      err_d  = 1'b0;
    end else begin
      if (wr_en)    err_d  = 1'b1;
      if (auto_set) mode_d = auto_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_CONT;
      rate_q <= RST_RATE;
      err_q  <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      rate_q <= rate_d;
      err_q  <= err_d;
    end
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run && (cnt_q == lim - CW'(1));
    cnt_en = clr || run;
    if (clr || done) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] wr_mode,
  input  logic [2:0] mode_q,
  input  logic       done,
  output logic       tmr_clr,
  output logic       tmr_run,
  output logic       osc_sel,
  output logic       commit_data,
  output logic       commit_off,
  output logic       commit_fs,
  output logic       auto_set,
  output logic [2:0] auto_mode,
  output logic       filt_run,
  output logic       pwr_dn
);

  seq_state_e st_q, st_d;
  logic       half_q, half_d;
  logic       st_en;

  always_comb begin
    st_d        = st_q;
    half_d      = half_q;
    tmr_clr     = accept;
    commit_data = 1'b0;
    commit_off  = 1'b0;
    commit_fs   = 1'b0;
    auto_set    = 1'b0;
    auto_mode   = M_IDLE;
    if (accept) begin
      half_d = 1'b0;
      case (wr_mode)
        M_CONT:   st_d = ST_CONV;
        M_SINGLE: st_d = ST_OSC;
        M_IDLE:   st_d = ST_IDLE;
        M_PDOWN:  st_d = ST_PDN;
        default:  st_d = ST_CAL;
      endcase
    end else if (done) begin
      case (st_q)
        ST_CONV: begin
          if (half_q) commit_data = 1'b1;
          else        half_d      = 1'b1;
        end
        ST_OSC: st_d = ST_SGL;
        ST_SGL: begin
          if (half_q) begin
            commit_data = 1'b1;
            auto_set    = 1'b1;
            auto_mode   = M_PDOWN;
            st_d        = ST_PDN;
            half_d      = 1'b0;
          end else begin
            half_d = 1'b1;
          end
        end
        ST_CAL: begin
          if (half_q) begin
            commit_fs  = (mode_q == M_FS_SYS);
            commit_off = (mode_q != M_FS_SYS);
            auto_set   = 1'b1;
            auto_mode  = M_IDLE;
            st_d       = ST_IDLE;
            half_d     = 1'b0;
          end else begin
            half_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
    st_en = accept || done;
  end

  always_comb begin
    tmr_run  = (st_q == ST_CONV) || (st_q == ST_OSC) ||
               (st_q == ST_SGL)  || (st_q == ST_CAL);
    osc_sel  = (st_q == ST_OSC);
    filt_run = (st_q == ST_CONV) || (st_q == ST_SGL) || (st_q == ST_CAL);
    pwr_dn   = (st_q == ST_PDN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CONV;
      half_q <= 1'b0;
    end else if (st_en) begin
      st_q   <= st_d;
      half_q <= half_d;
    end
  end

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic          commit_data,
  input  logic          commit_off,
  input  logic          commit_fs,
  input  logic          commit_any,
  input  logic          accept,
  input  logic          rd,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] off_q,
  output logic [DW-1:0] fs_q,
  output logic          ready_n
);

  logic [DW-1:0] smp_q;
  logic          rdy_d;
  logic          rdy_en;

  always_comb begin
    rdy_en = commit_any || accept || rd;
    rdy_d  = !commit_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   smp_q <= '0;
    else if (cap) smp_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           data_q <= '0;
    else if (commit_data) data_q <= smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          off_q <= '0;
    else if (commit_off) off_q <= smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fs_q <= '0;
    else if (commit_fs) fs_q <= smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ready_n <= 1'b1;
    else if (rdy_en) ready_n <= rdy_d;
  end

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adc_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int unsigned CLK_KHZ  = 1000,
  parameter logic [3:0]  RST_RATE = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic [3:0]    cfg_rate,
  input  logic          rd_strobe,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          ready_n,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] offset_coef,
  output logic [DW-1:0] fullscale_coef,
  output logic [2:0]    cur_mode,
  output logic [3:0]    cur_rate,
  output logic          cfg_err,
  output logic          filt_run,
  output logic          pwr_dn
);

  localparam int unsigned MAX_TICKS = MAX_MS * CLK_KHZ;
  localparam int          CW        = $clog2(MAX_TICKS + 1);

  logic          accept;
  logic          auto_set;
  logic [2:0]    auto_mode;
  logic          tmr_clr, tmr_run, osc_sel, done;
  logic          commit_data, commit_off, commit_fs, commit_any;
  logic          cap;
  logic [CW-1:0] lim;

  adc_seq_cfg #(.RST_RATE(RST_RATE)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_mode   (cfg_mode),
    .wr_rate   (cfg_rate),
    .auto_set  (auto_set),
    .auto_mode (auto_mode),
    .accept    (accept),
    .mode_q    (cur_mode),
    .rate_q    (cur_rate),
    .err_q     (cfg_err)
  );

  always_comb begin
    if (osc_sel) lim = CW'(CLK_KHZ);
    else         lim = CW'(period_ms(cur_rate) * CLK_KHZ);
  end

  adc_seq_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .lim   (lim),
    .done  (done)
  );

  adc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .wr_mode     (cfg_mode),
    .mode_q      (cur_mode),
    .done        (done),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .osc_sel     (osc_sel),
    .commit_data (commit_data),
    .commit_off  (commit_off),
    .commit_fs   (commit_fs),
    .auto_set    (auto_set),
    .auto_mode   (auto_mode),
    .filt_run    (filt_run),
    .pwr_dn      (pwr_dn)
  );

  always_comb begin
    commit_any = commit_data || commit_off || commit_fs;
    cap        = res_valid && filt_run;
  end

  adc_seq_store #(.DW(DW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap),
    .din         (res_data),
    .commit_data (commit_data),
    .commit_off  (commit_off),
    .commit_fs   (commit_fs),
    .commit_any  (commit_any),
    .accept      (accept),
    .rd          (rd_strobe),
    .data_q      (data_out),
    .off_q       (offset_coef),
    .fs_q        (fullscale_coef),
    .ready_n     (ready_n)
  );

endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          accept,
  input logic          auto_set,
  input logic          rd_strobe,
  input logic          commit_any,
  input logic          ready_n,
  input logic [2:0]    cur_mode,
  input logic [3:0]    cur_rate,
  input logic          cfg_err,
  input logic [DW-1:0] data_out,
  input logic          pwr_dn,
  input logic          filt_run
);

  p_write_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ready_n && !cfg_err));

  p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !accept && !auto_set) |=> (cfg_err && $stable(cur_mode) && $stable(cur_rate)));

  p_no_rsvd_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != 3'b101);

  p_rate_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period_ms(cur_rate) != 0);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !commit_any) |=> ready_n);

  p_cal_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_n) && $past(cur_mode[2])) |-> (cur_mode == 3'b010 && !filt_run));

  p_single_pdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_n) && $past(cur_mode) == 3'b001) |-> (cur_mode == 3'b011 && pwr_dn));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_run && !accept && (cur_mode == 3'b010 || cur_mode == 3'b011)) |=> $stable(data_out));

endmodule

bind adc_mode_seq adc_mode_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .accept     (accept),
  .auto_set   (auto_set),
  .rd_strobe  (rd_strobe),
  .commit_any (commit_any),
  .ready_n    (ready_n),
  .cur_mode   (cur_mode),
  .cur_rate   (cur_rate),
  .cfg_err    (cfg_err),
  .data_out   (data_out),
  .pwr_dn     (pwr_dn),
  .filt_run   (filt_run)
);

// File: tb/adc_mode_seq_bench.sv
module adc_mode_seq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int unsigned KHZ        = 2;
  localparam int          DW         = 16;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_mode;
  logic [3:0]    cfg_rate;
  logic          rd_strobe;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          ready_n;
  logic [DW-1:0] data_out, offset_coef, fullscale_coef;
  logic [2:0]    cur_mode;
  logic [3:0]    cur_rate;
  logic          cfg_err, filt_run, pwr_dn;

  int n_chk = 0;
  int n_bad = 0;

  adc_mode_seq #(.DW(DW), .CLK_KHZ(KHZ), .RST_RATE(4'hA)) u_adc_mode_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .rd_strobe(rd_strobe), .res_valid(res_valid), .res_data(res_data),
    .ready_n(ready_n), .data_out(data_out), .offset_coef(offset_coef),
    .fullscale_coef(fullscale_coef), .cur_mode(cur_mode), .cur_rate(cur_rate),
    .cfg_err(cfg_err), .filt_run(filt_run), .pwr_dn(pwr_dn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Period in cycles per rate code (R10)
  function automatic int per(input logic [3:0] code);
    case (code)
      4'h3: return 8 * KHZ;    4'h4: return 16 * KHZ;
      4'h5: return 20 * KHZ;   4'h7: return 30 * KHZ;
      4'h9: return 60 * KHZ;   4'hA: return 60 * KHZ;
      4'hB: return 80 * KHZ;   4'hC: return 100 * KHZ;
      4'hD: return 120 * KHZ;  4'hE: return 160 * KHZ;
      4'hF: return 240 * KHZ;  default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_rate = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Counts edges until ready_n is low; optionally injects one write at count inj_at.
  task automatic wait_rdy(input int limit, input int inj_at, input logic [2:0] im,
                          input logic [3:0] ir, output int n);
    n = 0;
    while (n < limit) begin
      if (n == inj_at) begin cfg_we = 1'b1; cfg_mode = im; cfg_rate = ir; end
      @(posedge clk);
      n++;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!ready_n) break;
    end
  endtask

  task automatic wait_data(input logic [DW-1:0] old, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (data_out != old) break;
    end
  endtask

  task automatic t_reset();
    chk(cur_mode == 3'b000, "R1 mode", cur_mode, 0);
    chk(cur_rate == 4'hA, "R1 rate", cur_rate, 4'hA);
    chk(ready_n == 1'b1, "R1 ready_n", ready_n, 1);
    chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);
    chk(data_out == 0 && offset_coef == 0 && fullscale_coef == 0, "R1 regs", data_out, 0);
    chk(filt_run == 1'b1 && pwr_dn == 1'b0, "R1 run", {filt_run, pwr_dn}, 2'b10);
  endtask

  task automatic t_power_on();
    int n;
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(n == 2 * per(4'hA), "R2 first after reset", n, 2 * per(4'hA));
    chk(data_out == 16'h1234, "R2 data", data_out, 16'h1234);
  endtask

  task automatic t_period_and_read();
    int n;
    res_data  = 16'h2222;
    rd_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(ready_n == 1'b1, "R4 read clears", ready_n, 1);
    chk(data_out == 16'h1234, "R4 data kept", data_out, 16'h1234);
    wait_data(16'h1234, 1000, n);
    chk(n + 1 == per(4'hA), "R3 next period", n + 1, per(4'hA));
    chk(data_out == 16'h2222 && ready_n == 1'b0, "R3 data", data_out, 16'h2222);
  endtask

  task automatic t_rates();
    int n;
    res_data = 16'h0333;
    wr(3'b000, 4'h3);
    chk(ready_n == 1'b1, "R11 write raises ready_n", ready_n, 1);
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(n == 2 * per(4'h3), "R10 code 3 first", n, 2 * per(4'h3));
    res_data = 16'h0334;
    wait_data(16'h0333, 1000, n);
    chk(n == per(4'h3), "R3 code 3 period", n, per(4'h3));
    foreach (res_data[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [3:0] c;
      c = (k == 0) ? 4'hF : (k == 1) ? 4'h5 : 4'hC;
      wr(3'b000, c);
      wait_rdy(2000, -1, 3'b0, 4'h0, n);
      chk(n == 2 * per(c), "R10 first result", n, 2 * per(c));
      chk(cur_rate == c, "R10 rate held", cur_rate, c);
    end
    // Restart in the middle of a conversion
    res_data = 16'h0440;
    wr(3'b000, 4'h3);
    wait_rdy(1000, 20, 3'b000, 4'h3, n);
    chk(n == 21 + 2 * per(4'h3), "R11 restart", n, 21 + 2 * per(4'h3));
    chk(data_out == 16'h0440, "R11 data", data_out, 16'h0440);
  endtask

  task automatic t_single();
    int n;
    res_data = 16'h5A5A;
    wr(3'b001, 4'h3);
    chk(filt_run == 1'b0 && pwr_dn == 1'b0, "R5 osc wait halted", {filt_run, pwr_dn}, 0);
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(n == int'(KHZ) + 2 * per(4'h3), "R5 latency", n, int'(KHZ) + 2 * per(4'h3));
    chk(data_out == 16'h5A5A, "R5 data", data_out, 16'h5A5A);
    chk(cur_mode == 3'b011 && pwr_dn == 1'b1 && filt_run == 1'b0, "R5 power-down", cur_mode, 3);
    res_data = 16'h7777;
    repeat (40) @(negedge clk);
    chk(ready_n == 1'b0, "R5 ready held", ready_n, 0);
    chk(data_out == 16'h5A5A, "R8 data frozen in power-down", data_out, 16'h5A5A);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(ready_n == 1'b1, "R5 read releases", ready_n, 1);
  endtask

  task automatic t_cal();
    int n;
    logic [DW-1:0] keep;
    keep = data_out;
    res_data = 16'h0F0F;
    wr(3'b100, 4'h3);
    chk(ready_n == 1'b1, "R6 start ready high", ready_n, 1);
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(n == 2 * per(4'h3), "R6 cal length", n, 2 * per(4'h3));
    chk(offset_coef == 16'h0F0F, "R6 internal zero to offset", offset_coef, 16'h0F0F);
    chk(data_out == keep, "R6 data untouched", data_out, keep);
    chk(cur_mode == 3'b010 && filt_run == 1'b0, "R7 idle after cal", cur_mode, 2);
    res_data = 16'h0E0E;
    wr(3'b110, 4'h4);
    chk(ready_n == 1'b1, "R6 start ready high again", ready_n, 1);
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(n == 2 * per(4'h4) && offset_coef == 16'h0E0E, "R6 system zero to offset", offset_coef, 16'h0E0E);
    res_data = 16'hF00D;
    wr(3'b111, 4'h3);
    wait_rdy(1000, -1, 3'b0, 4'h0, n);
    chk(fullscale_coef == 16'hF00D, "R6 full-scale reg", fullscale_coef, 16'hF00D);
    chk(offset_coef == 16'h0E0E, "R6 offset untouched", offset_coef, 16'h0E0E);
    chk(cur_mode == 3'b010, "R7 idle after full-scale cal", cur_mode, 2);
  endtask

  task automatic t_idle_pdn();
    logic [DW-1:0] keep;
    keep = data_out;
    wr(3'b010, 4'h3);
    res_data = 16'hBEEF;
    repeat (100) @(negedge clk);
    chk(ready_n == 1'b1 && data_out == keep, "R8 idle quiet", data_out, keep);
    chk(filt_run == 1'b0 && pwr_dn == 1'b0, "R8 idle flags", {filt_run, pwr_dn}, 0);
    wr(3'b011, 4'h3);
    repeat (100) @(negedge clk);
    chk(ready_n == 1'b1 && data_out == keep, "R8 power-down quiet", data_out, keep);
    chk(filt_run == 1'b0 && pwr_dn == 1'b1, "R8 power-down flags", {filt_run, pwr_dn}, 1);
  endtask

  task automatic t_reject();
    int n;
    logic [3:0] bad [5];
    bad = '{4'h0, 4'h1, 4'h2, 4'h6, 4'h8};
    wr(3'b010, 4'h3);
    wr(3'b101, 4'h3);
    chk(cfg_err == 1'b1, "R9 reserved mode flagged", cfg_err, 1);
    chk(cur_mode == 3'b010 && cur_rate == 4'h3, "R9 reserved kept", cur_mode, 2);
    for (int k = 0; k < 5; k++) begin
      wr(3'b000, bad[k]);
      chk(cfg_err == 1'b1 && cur_mode == 3'b010 && cur_rate == 4'h3 && filt_run == 1'b0,
          "R9 bad rate kept", cur_rate, 4'h3);
    end
    res_data = 16'h1357;
    wr(3'b000, 4'h3);
    chk(cfg_err == 1'b0, "R9 accepted write clears", cfg_err, 0);
    wait_rdy(1000, 10, 3'b101, 4'h4, n);
    chk(n == 2 * per(4'h3), "R9 reject keeps timing", n, 2 * per(4'h3));
    chk(cfg_err == 1'b1 && cur_rate == 4'h3, "R9 reject in flight", cur_rate, 4'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 3'b0; cfg_rate = 4'h0;
    rd_strobe = 1'b0; res_valid = 1'b1; res_data = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_power_on();
    t_period_and_read();
    t_rates();
    t_single();
    t_cal();
    t_idle_pdn();
    t_reject();
    summary();
    $finish;
  end

endmodule